// File: doc/BRIEF.md
# NAND Controller Register Front-End

This block sits between a simple byte-wide processor bus and the command sequencer of a NAND flash controller. Software talks to it through a small register map. One register starts the controller. Two registers declare how many devices are attached and which one is selected. Two more hold the interrupt status and the interrupt enables. Two byte-serial ports assemble an 8-byte configuration shadow and a 2-byte logical block address. Five event registers, for fast data, data, command, column address and row address, each turn a legal write into a one-cycle strobe for the sequencer, together with the written byte.

The block guards the sequencer against misuse. Selecting a device that was never declared is an illegal operation. Writing any event register while the controller is running is also illegal. An illegal write is discarded and sets a sticky status bit. When an enabled interrupt fires, the run flag drops on the same clock edge. The sequencer reports completion on a `seq_done` pulse, which is a second interrupt source.

Register map (4-bit address): 0x0 action (bit 0 = run), 0x1 device select, 0x2 device count, 0x3 interrupt status, 0x4 interrupt enable, 0x5 configuration port, 0x6 block address port, 0x8 fast data, 0x9 data, 0xA command, 0xB column address, 0xC row address. Status and enable use bit 0 for illegal operation and bit 1 for sequencer done.

Top module: `nandc_regfront`

## Requirements
- R1: After reset, all stored registers, the run flag, `irq`, `evt_stb`, `cfg_valid`, `cfg_bytes`, `lba` and `dev_sel` are zero, and every readable register reads 0x00.
- R2: A write to device select (0x1) whose value is equal to or greater than the device count (0x2) sets status bit 0 and leaves `dev_sel` unchanged. A smaller value is stored and appears on `dev_sel`.
- R3: A write to any event register (0x8 to 0xC) while the run flag is 1 sets status bit 0. It produces no strobe and leaves `evt_data` unchanged.
- R4: A write to the action register (0x0) never sets status bit 0. While `irq` is low, the write loads the run flag from bit 0 of the data, and a read of 0x0 returns the run flag in bit 0.
- R5: `irq` equals the OR of the status bits ANDed with their enable bits. On the edge where `irq` becomes 1, the run flag is cleared, and it stays 0 while `irq` is 1.
- R6: Status bits are sticky. Writing 1 to a status bit in 0x3 clears it, unless its source fires in the same cycle, in which case the bit stays set.
- R7: A legal event write made while the run flag is 0 raises the matching bit of `evt_stb` for exactly the following cycle: bit 0 fast data, bit 1 data, bit 2 command, bit 3 column address, bit 4 row address. The written byte appears on `evt_data` at the same time.
- R8: Successive writes to 0x5 fill configuration bytes 0 to 7 in order; byte k sits at `cfg_bytes[8k+7:8k]`. The eighth write raises `cfg_valid` for one cycle, and further writes are ignored.
- R9: A read of 0x5 resets the configuration byte pointer, so the next write goes to byte 0.
- R10: Writes to 0x6 go to `lba[15:8]` first and then `lba[7:0]`, after which the pointer wraps. A read of 0x6 resets the pointer to the most significant byte.
- R11: A `seq_done` pulse sets status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (ignored when bus_wr is high) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| seq_done | input | 1 | Completion pulse from the sequencer |
| run | output | 1 | Controller run flag |
| irq | output | 1 | Interrupt request |
| dev_sel | output | 8 | Selected device index |
| evt_stb | output | 5 | One-hot event strobes |
| evt_data | output | 8 | Byte carried by the latest legal event |
| cfg_bytes | output | 64 | Assembled configuration bytes |
| cfg_valid | output | 1 | Pulse when the eighth configuration byte is written |
| lba | output | 16 | Assembled logical block address |

## Verification
The hardest situation to reach from the ports is an event write that arrives while the run flag is 1. Bringing it about needs several register writes in a set order: the pending status must be clear, and the enables must not force `irq` high, before the action write can make run stick. The bench runs a directed sequence that builds this state on purpose. Random traffic then favours action writes, small device indices and a status clear mixed in often, so that running, enabled, masked and collision cases keep recurring. The random traffic also includes configuration reads in the middle of a fill and set-versus-clear collisions on the status register.

// File: rtl/nandc_pkg.sv
package nandc_pkg;
   localparam int ADDR_W = 4;
   localparam logic [3:0] A_ACT    = 4'h0;
   localparam logic [3:0] A_DEVSEL = 4'h1;
   localparam logic [3:0] A_NDEV   = 4'h2;
   localparam logic [3:0] A_STAT   = 4'h3;
   localparam logic [3:0] A_EN     = 4'h4;
   localparam logic [3:0] A_CFG    = 4'h5;
   localparam logic [3:0] A_LBA    = 4'h6;
   localparam logic [3:0] A_FDAT   = 4'h8;
   localparam logic [3:0] A_ROW    = 4'hC;
   localparam int NUM_EVT  = 5;
   localparam int NUM_IRQ  = 2;
   localparam int IRQ_ILL  = 0;
   localparam int IRQ_DONE = 1;
endpackage

// File: rtl/nandc_byte_loader.sv
module nandc_byte_loader #(
   parameter int N         = 8,
   parameter bit MSB_FIRST = 1'b0,
   parameter bit WRAP      = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic           ptr_clr,
   input  logic [7:0]     wdata,
   output logic [N*8-1:0] bytes_o,
   output logic           last_o
);
   localparam int PW = $clog2(N + 1);
   localparam logic [PW-1:0] P_LAST = PW'(N - 1);
   localparam logic [PW-1:0] P_END  = PW'(N);

   if (N < 1) begin : g_bad_n
      $error("nandc_byte_loader: N must be at least 1");
   end

   logic [PW-1:0] ptr_q;
   logic          accept;

   assign accept = wr_en && (ptr_q < P_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         last_o <= 1'b0;
      end else begin
         last_o <= accept && (ptr_q == P_LAST);
         if (accept) begin
            if (ptr_q == P_LAST) ptr_q <= WRAP ? '0 : P_END;
            else                 ptr_q <= ptr_q + 1'b1;
         end else if (ptr_clr) begin
            ptr_q <= '0;
         end
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_byte
      localparam logic [PW-1:0] SLOT = MSB_FIRST ? PW'(N - 1 - i) : PW'(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         bytes_o[i*8 +: 8] <= 8'h00;
         else if (accept && ptr_q == SLOT)   bytes_o[i*8 +: 8] <= wdata;
      end
   end
endmodule

// File: rtl/nandc_irq_ctl.sv
module nandc_irq_ctl #(
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic            clr_wr,
   input  logic            en_wr,
   input  logic [7:0]      wdata,
   input  logic            act_wr,
   input  logic            act_run,
   output logic [NSRC-1:0] status_o,
   output logic [NSRC-1:0] enable_o,
   output logic            run_o,
   output logic            irq_o
);
   if (NSRC < 1 || NSRC > 8) begin : g_bad_nsrc
      $error("nandc_irq_ctl: NSRC must be 1..8");
   end

   logic [NSRC-1:0] status_n, enable_n;
   logic            irq_n, run_n;

   always_comb begin
      status_n = (status_o & ~(clr_wr ? wdata[NSRC-1:0] : '0)) | set_i;
      enable_n = en_wr ? wdata[NSRC-1:0] : enable_o;
      irq_n    = |(status_n & enable_n);
      if (irq_n)       run_n = 1'b0;
      else if (act_wr) run_n = act_run;
      else             run_n = run_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_o <= '0;
         enable_o <= '0;
         run_o    <= 1'b0;
      end else begin
         status_o <= status_n;
         enable_o <= enable_n;
         run_o    <= run_n;
      end
   end

   assign irq_o = |(status_o & enable_o);
endmodule

// File: rtl/nandc_evt_strobe.sv
module nandc_evt_strobe #(
   parameter int NEVT = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fire,
   input  logic [$clog2(NEVT)-1:0] idx,
   input  logic [7:0]              wdata,
   output logic [NEVT-1:0]         stb_o,
   output logic [7:0]              data_o
);
   for (genvar e = 0; e < NEVT; e++) begin : g_stb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stb_o[e] <= 1'b0;
         else        stb_o[e] <= fire && (idx == ($clog2(NEVT))'(e));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    data_o <= 8'h00;
      else if (fire) data_o <= wdata;
   end
endmodule

// File: rtl/nandc_regfront.sv
module nandc_regfront
   import nandc_pkg::*;
#(
   parameter int CFG_BYTES = 8,
   parameter int LBA_BYTES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic                   bus_rd,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [7:0]             bus_wdata,
   output logic [7:0]             bus_rdata,
   input  logic                   seq_done,
   output logic                   run,
   output logic                   irq,
   output logic [7:0]             dev_sel,
   output logic [NUM_EVT-1:0]     evt_stb,
   output logic [7:0]             evt_data,
   output logic [CFG_BYTES*8-1:0] cfg_bytes,
   output logic                   cfg_valid,
   output logic [LBA_BYTES*8-1:0] lba
);
   localparam int EIW = $clog2(NUM_EVT);

   if (CFG_BYTES < 2) begin : g_bad_cfg
      $error("nandc_regfront: CFG_BYTES must be at least 2");
   end
   if (LBA_BYTES < 1) begin : g_bad_lba
      $error("nandc_regfront: LBA_BYTES must be at least 1");
   end

   logic               rd_eff;
   logic               w_act, w_dev, w_ndev, w_stat, w_en, w_cfg, w_lba, w_evt;
   logic               r_cfg, r_lba;
   logic               dev_bad, evt_bad, evt_ok;
   logic [EIW-1:0]     evt_idx;
   logic [7:0]         ndev_q;
   logic [NUM_IRQ-1:0] stat_q, en_q, irq_set;

   assign rd_eff = bus_rd && !bus_wr;

   always_comb begin
      w_act = 1'b0; w_dev = 1'b0; w_ndev = 1'b0; w_stat = 1'b0;
      w_en  = 1'b0; w_cfg = 1'b0; w_lba  = 1'b0;
      if (bus_wr) begin
         case (bus_addr)
            A_ACT:    w_act  = 1'b1;
            A_DEVSEL: w_dev  = 1'b1;
            A_NDEV:   w_ndev = 1'b1;
            A_STAT:   w_stat = 1'b1;
            A_EN:     w_en   = 1'b1;
            A_CFG:    w_cfg  = 1'b1;
            A_LBA:    w_lba  = 1'b1;
            default:  ;
         endcase
      end
   end

   assign w_evt   = bus_wr && (bus_addr >= A_FDAT) && (bus_addr <= A_ROW);
   assign evt_idx = EIW'(bus_addr - A_FDAT);
   assign r_cfg   = rd_eff && (bus_addr == A_CFG);
   assign r_lba   = rd_eff && (bus_addr == A_LBA);

   assign dev_bad = w_dev && (bus_wdata >= ndev_q);
   assign evt_bad = w_evt && run;
   assign evt_ok  = w_evt && !run;

   always_comb begin
      irq_set           = '0;
      irq_set[IRQ_ILL]  = dev_bad || evt_bad;
      irq_set[IRQ_DONE] = seq_done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ndev_q  <= 8'h00;
         dev_sel <= 8'h00;
      end else begin
         if (w_ndev)            ndev_q  <= bus_wdata;
         if (w_dev && !dev_bad) dev_sel <= bus_wdata;
      end
   end

   nandc_irq_ctl #(.NSRC(NUM_IRQ)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (irq_set),
      .clr_wr   (w_stat),
      .en_wr    (w_en),
      .wdata    (bus_wdata),
      .act_wr   (w_act),
      .act_run  (bus_wdata[0]),
      .status_o (stat_q),
      .enable_o (en_q),
      .run_o    (run),
      .irq_o    (irq)
   );

   nandc_evt_strobe #(.NEVT(NUM_EVT)) u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (evt_ok),
      .idx    (evt_idx),
      .wdata  (bus_wdata),
      .stb_o  (evt_stb),
      .data_o (evt_data)
   );

   nandc_byte_loader #(.N(CFG_BYTES), .MSB_FIRST(1'b0), .WRAP(1'b0)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (w_cfg),
      .ptr_clr (r_cfg),
      .wdata   (bus_wdata),
      .bytes_o (cfg_bytes),
      .last_o  (cfg_valid)
   );

   logic lba_last_unused;
   nandc_byte_loader #(.N(LBA_BYTES), .MSB_FIRST(1'b1), .WRAP(1'b1)) u_lba (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (w_lba),
      .ptr_clr (r_lba),
      .wdata   (bus_wdata),
      .bytes_o (lba),
      .last_o  (lba_last_unused)
   );

   always_comb begin
      case (bus_addr)
         A_ACT:    bus_rdata = {7'b0, run};
         A_DEVSEL: bus_rdata = dev_sel;
         A_NDEV:   bus_rdata = ndev_q;
         A_STAT:   bus_rdata = {{(8-NUM_IRQ){1'b0}}, stat_q};
         A_EN:     bus_rdata = {{(8-NUM_IRQ){1'b0}}, en_q};
         default:  bus_rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/nandc_regfront_chk.sv
module nandc_regfront_chk
   import nandc_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [3:0]         bus_addr,
   input logic [7:0]         bus_wdata,
   input logic               run,
   input logic               irq,
   input logic               ill_stat,
   input logic [NUM_EVT-1:0] evt_stb,
   input logic               cfg_valid
);
   logic evt_w;
   assign evt_w = bus_wr && (bus_addr >= A_FDAT) && (bus_addr <= A_ROW);

   AST_BUSY_EVT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_w && run) |=> ill_stat); // R3
   AST_BUSY_EVT_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_w && run) |=> (evt_stb == '0)); // R3
   AST_ACT_NEVER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_ACT && !ill_stat) |=> !ill_stat); // R4
   AST_IRQ_HALTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !run); // R5
   AST_ILL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ill_stat && !(bus_wr && bus_addr == A_STAT && bus_wdata[IRQ_ILL])) |=> ill_stat); // R6
   AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evt_stb)); // R7
   AST_CFG_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |=> !cfg_valid); // R8
endmodule

bind nandc_regfront nandc_regfront_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .run       (run),
   .irq       (irq),
   .ill_stat  (stat_q[nandc_pkg::IRQ_ILL]),
   .evt_stb   (evt_stb),
   .cfg_valid (cfg_valid)
);

// File: tb/tb_nandc_regfront.sv
module tb_nandc_regfront;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, seq_done = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic        run, irq, cfg_valid;
   logic [7:0]  dev_sel, evt_data;
   logic [4:0]  evt_stb;
   logic [63:0] cfg_bytes;
   logic [15:0] lba;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   nandc_regfront dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_done(seq_done), .run(run),
      .irq(irq), .dev_sel(dev_sel), .evt_stb(evt_stb), .evt_data(evt_data),
      .cfg_bytes(cfg_bytes), .cfg_valid(cfg_valid), .lba(lba)
   );

   // requirement model
   bit         m_run;
   bit [1:0]   m_stat, m_en;
   bit [7:0]   m_ndev, m_dev, m_edata;
   bit [7:0]   m_cfg [8];
   int         m_cptr, m_lptr;
   bit [15:0]  m_lba;
   bit [4:0]   m_stb;
   bit         m_cv;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] cfg_pack();
      logic [63:0] v;
      for (int k = 0; k < 8; k++) v[k*8 +: 8] = m_cfg[k];
      return v;
   endfunction

   function automatic logic [7:0] exp_read(input logic [3:0] a);
      case (a)
         4'h0: return {7'b0, m_run};
         4'h1: return m_dev;
         4'h2: return m_ndev;
         4'h3: return {6'b0, m_stat};
         4'h4: return {6'b0, m_en};
         default: return 8'h00;
      endcase
   endfunction

   task automatic op(input bit w, input bit r, input logic [3:0] a, input logic [7:0] d, input bit dn);
      bit ill, irqn;
      @(negedge clk);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; seq_done = dn;
      #1;
      if (r && !w) chk(bus_rdata == exp_read(a), (a == 4'h1) ? "R2" : (a == 4'h3) ? "R6" : "R4",
                       64'(bus_rdata), 64'(exp_read(a)));
      ill = 1'b0; m_stb = '0; m_cv = 1'b0;
      if (w) begin
         case (a)
            4'h1: if (d >= m_ndev) ill = 1'b1; else m_dev = d;
            4'h2: m_ndev = d;
            4'h3: m_stat = m_stat & ~d[1:0];
            4'h4: m_en = d[1:0];
            4'h5: if (m_cptr < 8) begin
                     m_cfg[m_cptr] = d; m_cv = (m_cptr == 7); m_cptr++;
                  end
            4'h6: begin
                     if (m_lptr == 0) m_lba[15:8] = d; else m_lba[7:0] = d;
                     m_lptr = 1 - m_lptr;
                  end
            4'h8, 4'h9, 4'hA, 4'hB, 4'hC:
                  if (m_run) ill = 1'b1;
                  else begin m_stb = 5'b1 << (a - 4'h8); m_edata = d; end
            default: ;
         endcase
      end else if (r) begin
         if (a == 4'h5) m_cptr = 0;
         if (a == 4'h6) m_lptr = 0;
      end
      m_stat = m_stat | {dn, ill};
      irqn = |(m_stat & m_en);
      if (irqn) m_run = 1'b0;
      else if (w && a == 4'h0) m_run = d[0];
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; seq_done = 1'b0;
      chk(run == m_run, "R5 run", 64'(run), 64'(m_run));
      chk(irq == irqn, "R5 irq", 64'(irq), 64'(irqn));
      chk(evt_stb == m_stb, "R7 strobe", 64'(evt_stb), 64'(m_stb));
      chk(evt_data == m_edata, "R3 evt_data", 64'(evt_data), 64'(m_edata));
      chk(dev_sel == m_dev, "R2 dev_sel", 64'(dev_sel), 64'(m_dev));
      chk(cfg_bytes == cfg_pack(), "R8 cfg_bytes", cfg_bytes, cfg_pack());
      chk(cfg_valid == m_cv, "R8 cfg_valid", 64'(cfg_valid), 64'(m_cv));
      chk(lba == m_lba, "R10 lba", 64'(lba), 64'(m_lba));
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d); op(1'b1, 1'b0, a, d, 1'b0); endtask
   task automatic rd(input logic [3:0] a);                      op(1'b0, 1'b1, a, 8'h00, 1'b0); endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int k = 0; k < 8; k++) m_cfg[k] = 8'h00;
      m_cptr = 0; m_lptr = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({run, irq, evt_stb, cfg_valid} == '0, "R1 outputs", 64'({run, irq, evt_stb, cfg_valid}), 0);
      chk(cfg_bytes == 0 && lba == 0 && dev_sel == 0, "R1 data", cfg_bytes ^ 64'(lba), 0);
      rst_n = 1'b1;
      for (int a = 0; a < 5; a++) rd(4'(a));            // R1 register reads

      // R2: device 4 with 2 declared
      wr(4'h2, 8'd2);
      wr(4'h1, 8'd1);
      wr(4'h1, 8'd4);
      chk(dev_sel == 8'd1, "R2 bad select kept", 64'(dev_sel), 1);
      rd(4'h3);
      wr(4'h3, 8'hFF);

      // R4 action sets run; R3 busy event write; R5 enabled irq stops run
      wr(4'h4, 8'h01);
      wr(4'h0, 8'h01);
      chk(run == 1'b1, "R4 run set", 64'(run), 1);
      wr(4'h0, 8'h01);
      chk(irq == 1'b0, "R4 no illegal on action", 64'(irq), 0);
      wr(4'hA, 8'h5A);
      chk(evt_stb == 0 && run == 0 && irq == 1, "R3 busy write", 64'({evt_stb, run, irq}), 64'(1));
      wr(4'h0, 8'h01);
      chk(run == 1'b0, "R5 run held low", 64'(run), 0);
      wr(4'h3, 8'h01);
      wr(4'hA, 8'h33);
      chk(evt_stb == 5'b00100 && evt_data == 8'h33, "R7 command strobe", 64'({evt_stb, evt_data}), 64'({5'b00100, 8'h33}));

      // R11 sequencer done
      wr(4'h4, 8'h02);
      wr(4'h0, 8'h01);
      op(1'b0, 1'b0, 4'h7, 8'h00, 1'b1);
      chk(run == 0 && irq == 1, "R11 done stops run", 64'({run, irq}), 64'(1));
      op(1'b1, 1'b0, 4'h3, 8'h02, 1'b1);                // R6 set wins over clear
      rd(4'h3);
      wr(4'h3, 8'h03);
      wr(4'h4, 8'h00);

      // R8 configuration fill, R9 pointer reset
      for (int k = 0; k < 8; k++) wr(4'h5, 8'(8'h10 + k));
      wr(4'h5, 8'hEE);
      chk(cfg_bytes[63:56] == 8'h17, "R8 ninth ignored", 64'(cfg_bytes[63:56]), 64'(8'h17));
      rd(4'h5);
      wr(4'h5, 8'hC3);
      chk(cfg_bytes[7:0] == 8'hC3, "R9 restart at byte 0", 64'(cfg_bytes[7:0]), 64'(8'hC3));

      // R10 block address
      wr(4'h6, 8'hAB); wr(4'h6, 8'hCD);
      chk(lba == 16'hABCD, "R10 msb first", 64'(lba), 64'(16'hABCD));
      wr(4'h6, 8'h11); rd(4'h6); wr(4'h6, 8'h22);
      chk(lba == 16'h22CD, "R10 read resets", 64'(lba), 64'(16'h22CD));

      // constrained random traffic
      for (int n = 0; n < 600; n++) begin
         int sel = $urandom_range(0, 15);
         logic [3:0] a;
         logic [7:0] d = 8'($urandom);
         bit rdop = ($urandom_range(0, 5) == 0);
         bit dn = ($urandom_range(0, 15) == 0);
         case (sel)
            0, 1, 2: begin a = 4'h0; d[0] = ($urandom_range(0, 3) != 0); end
            3:       begin a = 4'h1; d = 8'($urandom_range(0, 6)); end
            4:       begin a = 4'h2; d = 8'($urandom_range(0, 5)); end
            5, 6:    a = 4'h3;
            7:       a = 4'h4;
            8:       a = 4'h5;
            9:       a = 4'h6;
            15:      a = 4'h7;
            default: a = 4'(4'h8 + $urandom_range(0, 4));
         endcase
         op(!rdop, rdop, a, d, dn);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule